// File: doc/BRIEF.md
# Read-Strobe Expansion Port to 8-bit I/O Bridge

This block lets a host expansion port that can only issue read cycles drive an 8-bit I/O peripheral with both reads and writes. The host selects one of two adjacent 64 KiB windows. A select in the lower window starts an I/O read. A select in the upper window, the one offset by 0x10000, starts an I/O write. The host has no write strobe, so a write carries its data byte on host address lines A8..A1. Host address lines A13..A9 pick one of 32 I/O registers at the fixed base 0x300.

Each accepted access produces one active-low I/O strobe. The strobe is held for `PULSE_CLKS` clocks and then released. For a 16-bit peripheral, a read access with the wide qualifier set loads the low byte of a latch from A8..A1. A later wide write supplies the high byte on A8..A1 and presents both bytes together. A wide read returns all 16 data lines. Narrow reads return the I/O byte on host data bits 15..8.

Top module: `rom_isa_bridge`

## Requirements
- R1: After reset, `isa_ior_n` and `isa_iow_n` are 1, `host_rdata` is 0xFFFF, `isa_wide` is 0, `isa_addr` is 0x300 and the low-byte latch holds 0x00.
- R2: When the bridge is idle and a clock edge samples `host_sel_rd` high, `isa_ior_n` goes low at that edge. It stays low for exactly `PULSE_CLKS` clocks, even if the select drops earlier. `isa_ior_n` and `isa_iow_n` are never low together.
- R3: When the bridge is idle and a clock edge samples `host_sel_wr` high (with `host_sel_rd` low), `isa_iow_n` goes low at that edge. It stays low for exactly `PULSE_CLKS` clocks.
- R4: At strobe assertion, `isa_addr` is loaded with 0x300 OR `host_addr[13:9]`. So bits 4..0 come from A13..A9 and bits 9..5 are 11000.
- R5: At strobe assertion, `isa_wdata` is loaded with `host_addr[8:1]`.
- R6: A narrow read returns {I/O byte, 0xFF} on `host_rdata`. The I/O byte is sampled from `isa_rdata` on the last clock of the read strobe. The value is shown from strobe release until the first edge that samples `host_sel_rd` low. At all other times `host_rdata` is 0xFFFF.
- R7: A read with `host_wide` high returns `isa_wide_rdata` unchanged on `host_rdata`, with the same timing as R6.
- R8: A wide read loads the latch with `host_addr[8:1]`. A wide write drives `isa_wide_wdata` = {`host_addr[8:1]`, latch} from strobe assertion. `isa_wide` follows `host_wide` at strobe assertion.
- R9: The latch clears to 0x00 when a wide write strobe is released. So a wide write with no new latch load presents 0x00 as its low byte.
- R10: `isa_addr`, `isa_wdata` and `isa_wide_wdata` stay stable while a strobe is low and for one clock after it rises.
- R11: After a strobe is released, the bridge accepts no new access until a clock edge samples both selects low. A select held high produces exactly one strobe.
- R12: If both selects are high when an access is accepted, it is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 13 | Host address lines A13..A1 |
| host_sel_rd | input | 1 | Select of the lower (read) window |
| host_sel_wr | input | 1 | Select of the upper (write) window |
| host_wide | input | 1 | Access targets the 16-bit peripheral |
| host_rdata | output | 16 | Read data to the host |
| isa_addr | output | 10 | I/O address |
| isa_ior_n | output | 1 | Active-low I/O read strobe |
| isa_iow_n | output | 1 | Active-low I/O write strobe |
| isa_wdata | output | 8 | I/O write byte |
| isa_wide_wdata | output | 16 | 16-bit write word for the wide peripheral |
| isa_wide | output | 1 | Current cycle targets the wide peripheral |
| isa_rdata | input | 8 | I/O read byte |
| isa_wide_rdata | input | 16 | 16-bit read word from the wide peripheral |

## Verification
Strobes, address and write data change at the first edge that samples a select. Read data appears on the host bus `PULSE_CLKS` edges later. It falls back to 0xFFFF at the first edge that samples `host_sel_rd` low. The latch clears at the release edge of a wide write. The bench drives inputs on falling edges and steps a behavioural model on rising edges. It compares every output on the following falling edge, so each value is checked in the cycle it is due. The directed checks sample at a fixed count of falling edges after the select rises: one for the strobe and address, and `PULSE_CLKS`+1 for release and read data.

// File: rtl/rib_pkg.sv
package rib_pkg;
  localparam int IDX_W  = 5;
  localparam int BYTE_W = 8;
  localparam int IO_AW  = 10;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_HOLD,
    ST_WAIT
  } rib_state_e;

  typedef struct packed {
    logic              wr;
    logic              wide;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] dbyte;
  } rib_req_t;
endpackage

// File: rtl/rib_decode.sv
module rib_decode
  import rib_pkg::*;
(
  input  logic [13:1] host_addr,
  input  logic        host_sel_rd,
  input  logic        host_sel_wr,
  input  logic        host_wide,
  output rib_req_t    req,
  output logic        req_valid,
  output logic        sel_any
);
  always_comb begin
    sel_any   = host_sel_rd | host_sel_wr;
    req_valid = sel_any;
    // read window wins when both are selected
    req.wr    = host_sel_wr & ~host_sel_rd;
    req.wide  = host_wide;
    req.idx   = host_addr[13:9];
    req.dbyte = host_addr[8:1];
  end
endmodule

// File: rtl/rib_seq.sv
module rib_seq
  import rib_pkg::*;
#(
  parameter int PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_wr,
  input  logic sel_any,
  output logic accept,
  output logic release_o,
  output logic ior_n,
  output logic iow_n
);
  localparam int CNT_W = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CLKS - 1);

  rib_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ior_n_q, ior_n_d;
  logic             iow_n_q, iow_n_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ior_n_d   = ior_n_q;
    iow_n_d   = iow_n_q;
    accept    = 1'b0;
    release_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_PULSE;
          cnt_d   = CNT_LOAD;
          ior_n_d = req_wr;
          iow_n_d = ~req_wr;
        end
      end
      ST_PULSE: begin
        if (cnt_q == '0) begin
          release_o = 1'b1;
          state_d   = ST_HOLD;
          ior_n_d   = 1'b1;
          iow_n_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: state_d = ST_WAIT;
      ST_WAIT: if (!sel_any) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ior_n_q <= 1'b1;
      iow_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ior_n_q <= ior_n_d;
      iow_n_q <= iow_n_d;
    end
  end

  assign ior_n = ior_n_q;
  assign iow_n = iow_n_q;
endmodule

// File: rtl/rib_datapath.sv
module rib_datapath
  import rib_pkg::*;
#(
  parameter logic [IO_AW-1:0] IO_BASE = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              release_i,
  input  rib_req_t          req,
  input  logic              host_sel_rd,
  input  logic [BYTE_W-1:0] isa_rdata,
  input  logic [WORD_W-1:0] isa_wide_rdata,
  output logic [IO_AW-1:0]  isa_addr,
  output logic [BYTE_W-1:0] isa_wdata,
  output logic [WORD_W-1:0] isa_wide_wdata,
  output logic              isa_wide,
  output logic [WORD_W-1:0] host_rdata
);
  localparam logic [IO_AW-IDX_W-1:0] BASE_HI = IO_BASE[IO_AW-1:IDX_W];
  localparam logic [WORD_W-1:0]      IDLE_WORD = '1;

  logic [IO_AW-1:0]  addr_q, addr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic [WORD_W-1:0] wword_q, wword_d;
  logic              wide_q, wide_d;
  logic              cyc_wr_q, cyc_wr_d;
  logic [BYTE_W-1:0] lat_q, lat_d;
  logic [WORD_W-1:0] rd_q, rd_d;
  logic              rdv_q, rdv_d;
  logic              cap_en, wword_en, lat_load, lat_clr, rd_done;

  always_comb begin
    cap_en   = accept;
    wword_en = accept & req.wr;
    lat_load = accept & ~req.wr & req.wide;
    lat_clr  = release_i & cyc_wr_q & wide_q;
    rd_done  = release_i & ~cyc_wr_q;

    addr_d   = cap_en ? {BASE_HI, req.idx} : addr_q;
    wdat_d   = cap_en ? req.dbyte : wdat_q;
    wide_d   = cap_en ? req.wide : wide_q;
    cyc_wr_d = cap_en ? req.wr : cyc_wr_q;
    wword_d  = wword_en ? {req.dbyte, lat_q} : wword_q;

    lat_d = lat_q;
    if (lat_load)     lat_d = req.dbyte;
    else if (lat_clr) lat_d = '0;

    rd_d  = rd_q;
    rdv_d = rdv_q;
    if (rd_done) begin
      rd_d  = wide_q ? isa_wide_rdata : {isa_rdata, {BYTE_W{1'b1}}};
      rdv_d = 1'b1;
    end else if (!host_sel_rd) begin
      rdv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= IO_BASE;
      wdat_q   <= '0;
      wword_q  <= '0;
      wide_q   <= 1'b0;
      cyc_wr_q <= 1'b0;
      lat_q    <= '0;
      rd_q     <= IDLE_WORD;
      rdv_q    <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      wdat_q   <= wdat_d;
      wword_q  <= wword_d;
      wide_q   <= wide_d;
      cyc_wr_q <= cyc_wr_d;
      lat_q    <= lat_d;
      rd_q     <= rd_d;
      rdv_q    <= rdv_d;
    end
  end

  assign isa_addr       = addr_q;
  assign isa_wdata      = wdat_q;
  assign isa_wide_wdata = wword_q;
  assign isa_wide       = wide_q;
  assign host_rdata     = rdv_q ? rd_q : IDLE_WORD;
endmodule

// File: rtl/rom_isa_bridge.sv
module rom_isa_bridge
  import rib_pkg::*;
#(
  parameter int               PULSE_CLKS = 4,
  parameter logic [IO_AW-1:0] IO_BASE    = 10'h300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:1] host_addr,
  input  logic        host_sel_rd,
  input  logic        host_sel_wr,
  input  logic        host_wide,
  output logic [15:0] host_rdata,
  output logic [9:0]  isa_addr,
  output logic        isa_ior_n,
  output logic        isa_iow_n,
  output logic [7:0]  isa_wdata,
  output logic [15:0] isa_wide_wdata,
  output logic        isa_wide,
  input  logic [7:0]  isa_rdata,
  input  logic [15:0] isa_wide_rdata
);
  rib_req_t req;
  logic     req_valid, sel_any, accept, rel;

  rib_decode u_dec (
    .host_addr   (host_addr),
    .host_sel_rd (host_sel_rd),
    .host_sel_wr (host_sel_wr),
    .host_wide   (host_wide),
    .req         (req),
    .req_valid   (req_valid),
    .sel_any     (sel_any)
  );

  rib_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_wr    (req.wr),
    .sel_any   (sel_any),
    .accept    (accept),
    .release_o (rel),
    .ior_n     (isa_ior_n),
    .iow_n     (isa_iow_n)
  );

  rib_datapath #(.IO_BASE(IO_BASE)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .release_i      (rel),
    .req            (req),
    .host_sel_rd    (host_sel_rd),
    .isa_rdata      (isa_rdata),
    .isa_wide_rdata (isa_wide_rdata),
    .isa_addr       (isa_addr),
    .isa_wdata      (isa_wdata),
    .isa_wide_wdata (isa_wide_wdata),
    .isa_wide       (isa_wide),
    .host_rdata     (host_rdata)
  );
endmodule

// File: rtl/rib_chk.sv
module rib_chk #(
  parameter int PULSE_CLKS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        isa_ior_n,
  input logic        isa_iow_n,
  input logic [9:0]  isa_addr,
  input logic [7:0]  isa_wdata,
  input logic [15:0] isa_wide_wdata,
  input logic [15:0] host_rdata
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run_q <= '0;
    else if (!isa_ior_n || !isa_iow_n) low_run_q <= low_run_q + 1;
    else low_run_q <= '0;
  end

  // R2
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!isa_ior_n && !isa_iow_n));

  // R3 (and R2): every strobe lasts exactly PULSE_CLKS clocks
  a_r3_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isa_ior_n) || $rose(isa_iow_n)) |-> (low_run_q == 32'(PULSE_CLKS)));

  // R10
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_ior_n || !isa_iow_n) |=>
      ($stable(isa_addr) && $stable(isa_wdata) && $stable(isa_wide_wdata)));

  // R11
  a_r11_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isa_ior_n) || $rose(isa_iow_n)) |=> (isa_ior_n && isa_iow_n));

  // R6
  a_r6_idle_word_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_ior_n |-> (host_rdata == 16'hFFFF));
endmodule

bind rom_isa_bridge rib_chk #(.PULSE_CLKS(PULSE_CLKS)) u_rib_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .isa_ior_n      (isa_ior_n),
  .isa_iow_n      (isa_iow_n),
  .isa_addr       (isa_addr),
  .isa_wdata      (isa_wdata),
  .isa_wide_wdata (isa_wide_wdata),
  .host_rdata     (host_rdata)
);

// File: tb/rom_isa_bridge_tb_top.sv
`timescale 1ns/1ps
module rom_isa_bridge_tb_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] host_addr = '0;
  logic        host_sel_rd = 1'b0, host_sel_wr = 1'b0, host_wide = 1'b0;
  logic [7:0]  isa_rdata = 8'h00;
  logic [15:0] isa_wide_rdata = 16'h0000;
  logic [15:0] host_rdata, isa_wide_wdata;
  logic [9:0]  isa_addr;
  logic        isa_ior_n, isa_iow_n, isa_wide;
  logic [7:0]  isa_wdata;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rom_isa_bridge #(.PULSE_CLKS(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
    .host_sel_rd(host_sel_rd), .host_sel_wr(host_sel_wr), .host_wide(host_wide),
    .host_rdata(host_rdata), .isa_addr(isa_addr), .isa_ior_n(isa_ior_n),
    .isa_iow_n(isa_iow_n), .isa_wdata(isa_wdata), .isa_wide_wdata(isa_wide_wdata),
    .isa_wide(isa_wide), .isa_rdata(isa_rdata), .isa_wide_rdata(isa_wide_rdata)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_act, m_wr, m_wide, m_rdv;
  int          m_t;
  logic [9:0]  m_addr;
  logic [7:0]  m_wdat, m_lat;
  logic [15:0] m_ww, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_wide = 0; m_rdv = 0; m_t = 0;
      m_addr = 10'h300; m_wdat = 0; m_lat = 0; m_ww = 0; m_rd = 16'hFFFF;
    end else begin
      bit set_now;
      set_now = 0;
      if (!m_act) begin
        if (host_sel_rd || host_sel_wr) begin
          m_act  = 1; m_t = 0;
          m_wr   = !host_sel_rd;
          m_wide = host_wide;
          m_addr = 10'h300 | 10'(host_addr[13:9]);
          m_wdat = host_addr[8:1];
          if (m_wr) m_ww = {host_addr[8:1], m_lat};
          else if (m_wide) m_lat = host_addr[8:1];
        end
      end else if (m_t >= P + 1 && !host_sel_rd && !host_sel_wr) begin
        m_act = 0;
      end else begin
        m_t++;
        if (m_t == P) begin
          if (!m_wr) begin
            m_rdv = 1; set_now = 1;
            m_rd = m_wide ? isa_wide_rdata : {isa_rdata, 8'hFF};
          end else if (m_wide) m_lat = 8'h00;
        end
      end
      if (!set_now && !host_sel_rd) m_rdv = 0;
    end
  end

  // every-cycle comparison and strobe statistics
  int ior_falls = 0, iow_falls = 0, run = 0, last_run = 0;
  logic prev_ior = 1'b1, prev_iow = 1'b1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 ior_n vs model", {15'd0, isa_ior_n}, {15'd0, !(m_act && !m_wr && m_t < P)});
      chk("R3 iow_n vs model", {15'd0, isa_iow_n}, {15'd0, !(m_act && m_wr && m_t < P)});
      chk("R4 isa_addr vs model", {6'd0, isa_addr}, {6'd0, m_addr});
      chk("R5 isa_wdata vs model", {8'd0, isa_wdata}, {8'd0, m_wdat});
      chk("R8 isa_wide_wdata vs model", isa_wide_wdata, m_ww);
      chk("R8 isa_wide vs model", {15'd0, isa_wide}, {15'd0, m_wide});
      chk("R6 R7 host_rdata vs model", host_rdata, m_rdv ? m_rd : 16'hFFFF);
      if (prev_ior && !isa_ior_n) ior_falls++;
      if (prev_iow && !isa_iow_n) iow_falls++;
      if (!isa_ior_n || !isa_iow_n) run++;
      else if (run > 0) begin last_run = run; run = 0; end
      prev_ior = isa_ior_n;
      prev_iow = isa_iow_n;
    end
  end

  // one host access; directed checks at fixed falling-edge counts
  task automatic xact(bit rd, bit wr, bit wide, logic [4:0] idx, logic [7:0] dbyte,
                      int hold, logic [15:0] exp_rd, logic [15:0] exp_ww);
    @(negedge clk);
    host_addr = {idx, dbyte};
    host_sel_rd = rd; host_sel_wr = wr; host_wide = wide;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (rd) chk("R2 ior_n low one edge after select", {15'd0, isa_ior_n}, 16'd0);
        else    chk("R3 iow_n low one edge after select", {15'd0, isa_iow_n}, 16'd0);
        chk("R4 io address", {6'd0, isa_addr}, {6'd0, 10'h300 | 10'(idx)});
        chk("R5 write byte", {8'd0, isa_wdata}, {8'd0, dbyte});
        if (wr && !rd && wide) chk("R8 R9 wide write word", isa_wide_wdata, exp_ww);
      end
      if (k == P + 1) begin
        chk("R2 R3 strobes released", {14'd0, isa_ior_n, isa_iow_n}, 16'd3);
        if (rd) chk("R6 R7 read data", host_rdata, exp_rd);
      end
    end
    host_sel_rd = 0; host_sel_wr = 0; host_wide = 0;
    repeat (P + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ior_n", {15'd0, isa_ior_n}, 16'd1);
    chk("R1 reset iow_n", {15'd0, isa_iow_n}, 16'd1);
    chk("R1 reset host_rdata", host_rdata, 16'hFFFF);
    chk("R1 reset isa_wide", {15'd0, isa_wide}, 16'd0);
    chk("R1 reset isa_addr", {6'd0, isa_addr}, 16'h0300);

    isa_rdata = 8'hA5;
    xact(1, 0, 0, 5'h15, 8'h00, P + 3, 16'hA5FF, 16'h0);
    chk("R6 idle word after read", host_rdata, 16'hFFFF);
    xact(0, 1, 0, 5'h0A, 8'h3C, P + 3, 16'h0, 16'h0);
    // R1 R9: latch empty after reset
    xact(0, 1, 1, 5'h03, 8'h77, P + 3, 16'h0, 16'h7700);
    isa_wide_rdata = 16'hBEEF;
    xact(1, 0, 1, 5'h03, 8'h12, P + 3, 16'hBEEF, 16'h0);
    xact(0, 1, 1, 5'h03, 8'h34, P + 3, 16'h0, 16'h3412);
    xact(0, 1, 1, 5'h03, 8'h56, P + 3, 16'h0, 16'h5600);
    isa_rdata = 8'h5A;
    xact(1, 0, 0, 5'h1F, 8'hC3, P + 3, 16'h5AFF, 16'h0);

    begin
      int f0;
      f0 = ior_falls;
      xact(1, 0, 0, 5'h01, 8'h00, 3 * P + 2, 16'h5AFF, 16'h0);
      chk("R11 held select gives one strobe", 16'(ior_falls - f0), 16'd1);
    end

    xact(1, 0, 0, 5'h02, 8'h00, 1, 16'h0, 16'h0);
    chk("R2 full pulse after early select drop", 16'(last_run), 16'(P));

    begin
      int r0, w0;
      r0 = ior_falls; w0 = iow_falls;
      isa_rdata = 8'h81;
      xact(1, 1, 0, 5'h04, 8'h99, P + 3, 16'h81FF, 16'h0);
      chk("R12 both selects read strobe", 16'(ior_falls - r0), 16'd1);
      chk("R12 both selects no write strobe", 16'(iow_falls - w0), 16'd0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule